// File: doc/BRIEF.md
# Key Combination Hold Reset Timer

This block watches two key inputs and raises a reset request once a chosen key condition has been held without a break for a programmed number of slow timebase ticks. Each key passes through a two-flop synchronizer. A per-key enable decides which keys take part. A mode bit then combines the enabled keys either as "all pressed" or as "any pressed". The hold timeout is counted in ticks of a slow strobe, for example one pulse per millisecond, so a seven second hold is a setting of 7000.

On expiry the block issues a one-cycle request. An action bit selects whether that request goes out on the warm-reset output or on the shutdown output. A sticky flag records that a key-combination request happened. The configuration inputs are held by surrounding logic and stay in force for as long as the chip runs, so the block keeps watching the keys with no software involvement. After it fires, the block stays quiet until both keys have been let go. This stops a key that is still held from producing a burst of repeated requests.

Top module: `keyhold_reset`

## Requirements
- R1: A key whose enable input is 0 has no effect on the condition, whether it is pressed or not.
- R2: With `cfg_mode_and`=1 the condition is true when every enabled key is pressed. With `cfg_mode_and`=0 it is true when at least one enabled key is pressed. A key reads as pressed when its synchronized level is 1.
- R3: Key inputs pass through two flip-flops. The hold count rises by one on each cycle where `tick`=1 while the condition stays true and the block is armed. The request is issued in the clock after the count is at or above `cfg_hold_ticks`, so a setting of 0 fires one cycle after the condition is seen.
- R4: When the condition goes false at any point before expiry, the hold count returns to zero, and a later hold starts again from zero.
- R5: `cfg_action`=0 sends a one-cycle pulse on `warm_req`, and `cfg_action`=1 sends it on `shut_req`. The two outputs are never high together.
- R6: After a request the block issues no further request until both synchronized keys have read 0, whatever the enables are. Once that has happened it can fire again.
- R7: When both enables are 0 the block never issues a request, in either combine mode.
- R8: `reason_key` goes to 1 in the same cycle as any request and stays at 1 until reset.
- R9: While `rst_n` is low at a clock edge, both request outputs and `reason_key` go to 0, the count clears and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle slow timebase strobe |
| key_pri_raw | input | 1 | Primary key level, asynchronous, 1 = pressed |
| key_sec_raw | input | 1 | Secondary key level, asynchronous, 1 = pressed |
| cfg_en_pri | input | 1 | Primary key takes part when 1 |
| cfg_en_sec | input | 1 | Secondary key takes part when 1 |
| cfg_mode_and | input | 1 | 1 = all enabled keys, 0 = any enabled key |
| cfg_hold_ticks | input | CNT_W | Hold timeout in ticks |
| cfg_action | input | 1 | 0 = warm reset, 1 = shutdown |
| warm_req | output | 1 | One-cycle warm-reset request |
| shut_req | output | 1 | One-cycle shutdown request |
| reason_key | output | 1 | Sticky key-combination reason flag |

## Verification
The bench presses one key alone in all-keys mode. A design that treats the mode as "any" would fire there. It presses a disabled key in any-key mode, where a design that ignores the enables would fire. It also holds both keys with both enables off, which catches a design whose "all enabled keys" test is vacuously true.

Two short holds separated by a release must not add up to a timeout. A counter that pauses instead of clearing would fire on that pattern. A key left pressed after a request, followed by the other key being pressed again, must not re-fire. A design that re-arms on the condition alone, rather than on both keys being released, would send a second request. Every cycle is compared against a behavioural model, so a request that arrives a cycle early or late, or lands on the wrong output, shows as a miscompare.

// File: rtl/keyhold_pkg.sv
// Shared types and constants for the key hold reset timer.
// Assumes exactly two keys: primary at index 0, secondary at index 1.
package keyhold_pkg;
    localparam int unsigned NUM_KEYS = 2;
    localparam int unsigned KEY_PRI  = 0;
    localparam int unsigned KEY_SEC  = 1;

    typedef enum logic {
        ACT_WARM = 1'b0,
        ACT_SHUT = 1'b1
    } action_e;
endpackage

// File: rtl/keyhold_sync.sv
// Two-flop synchronizer for each key level.
// Assumes the keys are already debounced and change slowly compared with clk.
module keyhold_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_key
            logic meta_q;
            logic sync_q;
            // Shift the raw level through two flops; reset reads as released.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                end else begin
                    meta_q <= raw[g];
                    sync_q <= meta_q;
                end
            end
            assign synced[g] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/keyhold_combine.sv
// Combines the enabled keys into a single hold condition, as either
// "all enabled pressed" or "any enabled pressed".
// Assumes nothing about the enables. With no key enabled the condition is false.
module keyhold_combine #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] keys,
    input  logic [N-1:0] en,
    input  logic         mode_and,
    output logic         cond
);
    logic all_hit;
    logic any_hit;

    // Disabled keys count as satisfied for "all" and as absent for "any".
    always_comb begin
        all_hit = &(keys | ~en);
        any_hit = |(keys & en);
        if (en == '0)
            cond = 1'b0;
        else if (mode_and)
            cond = all_hit;
        else
            cond = any_hit;
    end
endmodule

// File: rtl/keyhold_timer.sv
// Hold counter with one-shot fire and re-arm on release of all keys.
// Assumes tick is a single-cycle strobe. hold may change at any time, and the
// comparison is at-or-above, so lowering it below the current count fires at once.
module keyhold_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cond,
    input  logic             keys_idle,
    input  logic [CNT_W-1:0] hold,
    output logic             fire,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Fire when armed, the condition holds and the count has reached the timeout.
    always_comb begin
        fire = armed_q && cond && (cnt_q >= hold);
    end

    // Count ticks while the condition holds. Clear on release, on firing or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!cond || !armed_q || fire)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Disarm on firing and re-arm only once every key reads released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (fire)
            armed_q <= 1'b0;
        else if (keys_idle)
            armed_q <= 1'b1;
    end

    assign cnt   = cnt_q;
    assign armed = armed_q;
endmodule

// File: rtl/keyhold_reset.sv
// Top of the key hold reset timer. Synchronizes two keys, combines them under
// the configured enables and mode, times the hold in slow ticks, and sends a
// one-cycle warm or shutdown request with a sticky reason flag.
// Assumes the configuration inputs are held static by their owner.
module keyhold_reset
    import keyhold_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_pri_raw,
    input  logic             key_sec_raw,
    input  logic             cfg_en_pri,
    input  logic             cfg_en_sec,
    input  logic             cfg_mode_and,
    input  logic [CNT_W-1:0] cfg_hold_ticks,
    input  logic             cfg_action,
    output logic             warm_req,
    output logic             shut_req,
    output logic             reason_key
);
    logic [NUM_KEYS-1:0] raw_keys;
    logic [NUM_KEYS-1:0] sync_keys;
    logic [NUM_KEYS-1:0] key_en;
    logic                hold_cond;
    logic                fire;
    logic                armed;
    logic [CNT_W-1:0]    hold_cnt;
    action_e             act;

    assign raw_keys[KEY_PRI] = key_pri_raw;
    assign raw_keys[KEY_SEC] = key_sec_raw;
    assign key_en[KEY_PRI]   = cfg_en_pri;
    assign key_en[KEY_SEC]   = cfg_en_sec;
    assign act               = action_e'(cfg_action);

    keyhold_sync #(.N(NUM_KEYS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_keys),
        .synced (sync_keys)
    );

    keyhold_combine #(.N(NUM_KEYS)) comb_i (
        .keys     (sync_keys),
        .en       (key_en),
        .mode_and (cfg_mode_and),
        .cond     (hold_cond)
    );

    keyhold_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cond      (hold_cond),
        .keys_idle (sync_keys == '0),
        .hold      (cfg_hold_ticks),
        .fire      (fire),
        .cnt       (hold_cnt),
        .armed     (armed)
    );

    // Route the fire pulse to the selected request output and latch the reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_req   <= 1'b0;
            shut_req   <= 1'b0;
            reason_key <= 1'b0;
        end else begin
            warm_req   <= fire && (act == ACT_WARM);
            shut_req   <= fire && (act == ACT_SHUT);
            reason_key <= reason_key || fire;
        end
    end
endmodule

// File: rtl/keyhold_reset_chk.sv
// Assertion checker for keyhold_reset, attached through bind.
// Assumes the synchronous active-low reset of the top module.
module keyhold_reset_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en_pri,
    input logic             cfg_en_sec,
    input logic             warm_req,
    input logic             shut_req,
    input logic             reason_key,
    input logic             hold_cond,
    input logic             armed,
    input logic [CNT_W-1:0] hold_cnt
);
    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(warm_req && shut_req));

    p_warm_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req |=> !warm_req);

    p_shut_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |=> !shut_req);

    p_reason_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_req || shut_req) |-> reason_key);

    p_reason_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reason_key |=> reason_key);

    p_no_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_en_pri) && !$past(cfg_en_sec)) |-> !(warm_req || shut_req));

    p_clear_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_cond |=> (hold_cnt == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |-> ((hold_cnt == $past(hold_cnt)) ||
                              (hold_cnt == $past(hold_cnt) + CNT_W'(1))));

    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_req || shut_req) |-> !armed);
endmodule

bind keyhold_reset keyhold_reset_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en_pri (cfg_en_pri),
    .cfg_en_sec (cfg_en_sec),
    .warm_req   (warm_req),
    .shut_req   (shut_req),
    .reason_key (reason_key),
    .hold_cond  (hold_cond),
    .armed      (armed),
    .hold_cnt   (hold_cnt)
);

// File: tb/keyhold_reset_tb.sv
// Bench for keyhold_reset: a behavioural reference model compared every clock,
// plus directed checks on request counts per scenario.
module keyhold_reset_tb_top;
    localparam int CNT_W = 16;
    localparam int HOLD  = 5;
    localparam int TICK_PERIOD = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             key_pri_raw = 1'b0;
    logic             key_sec_raw = 1'b0;
    logic             cfg_en_pri = 1'b0;
    logic             cfg_en_sec = 1'b0;
    logic             cfg_mode_and = 1'b0;
    logic [CNT_W-1:0] cfg_hold_ticks = CNT_W'(HOLD);
    logic             cfg_action = 1'b0;
    logic             warm_req;
    logic             shut_req;
    logic             reason_key;

    int vectors = 0;
    int errors  = 0;
    int warm_seen = 0;
    int shut_seen = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyhold_reset #(.CNT_W(CNT_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .key_pri_raw    (key_pri_raw),
        .key_sec_raw    (key_sec_raw),
        .cfg_en_pri     (cfg_en_pri),
        .cfg_en_sec     (cfg_en_sec),
        .cfg_mode_and   (cfg_mode_and),
        .cfg_hold_ticks (cfg_hold_ticks),
        .cfg_action     (cfg_action),
        .warm_req       (warm_req),
        .shut_req       (shut_req),
        .reason_key     (reason_key)
    );

    // Reference model state
    bit m_pa1, m_pa2, m_sa1, m_sa2;
    int m_cnt = 0;
    bit m_armed = 1'b1;
    bit m_warm = 1'b0, m_shut = 1'b0, m_reason = 1'b0;

    // Behavioural model of the requirements, updated at each rising edge.
    always @(posedge clk) begin
        bit kp, ks, cond, fire;
        if (!rst_n) begin
            m_pa1 = 0; m_pa2 = 0; m_sa1 = 0; m_sa2 = 0;
            m_cnt = 0; m_armed = 1; m_warm = 0; m_shut = 0; m_reason = 0;
        end else begin
            kp = m_pa2; ks = m_sa2;
            if (!cfg_en_pri && !cfg_en_sec) cond = 0;
            else if (cfg_mode_and) cond = (!cfg_en_pri || kp) && (!cfg_en_sec || ks);
            else cond = (cfg_en_pri && kp) || (cfg_en_sec && ks);
            fire = m_armed && cond && (m_cnt >= int'(cfg_hold_ticks));
            m_warm = fire && !cfg_action;
            m_shut = fire && cfg_action;
            if (fire) m_reason = 1;
            if (!cond || !m_armed || fire) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            if (fire) m_armed = 0;
            else if (!kp && !ks) m_armed = 1;
            m_pa2 = m_pa1; m_pa1 = key_pri_raw;
            m_sa2 = m_sa1; m_sa1 = key_sec_raw;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            vectors++;
            if (warm_req !== m_warm || shut_req !== m_shut) begin
                errors++;
                $display("FAIL R5 model compare cycle %0d: warm/shut=%b%b expected %b%b",
                         cyc, warm_req, shut_req, m_warm, m_shut);
            end
            if (reason_key !== m_reason) begin
                errors++;
                $display("FAIL R8 model compare cycle %0d: reason=%b expected %b",
                         cyc, reason_key, m_reason);
            end
            if (warm_req) warm_seen++;
            if (shut_req) shut_seen++;
        end
    end

    // Slow tick strobe, one cycle in every TICK_PERIOD.
    initial begin
        forever begin
            repeat (TICK_PERIOD - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic keys(input bit p, input bit s, input int n);
        @(negedge clk);
        key_pri_raw = p;
        key_sec_raw = s;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int w0, s0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!warm_req && !shut_req && !reason_key, "R9 reset outputs",
              int'({warm_req, shut_req, reason_key}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and R1: all-keys mode, only one key pressed, no request
        cfg_en_pri = 1; cfg_en_sec = 1; cfg_mode_and = 1; cfg_action = 0;
        w0 = warm_seen;
        keys(1, 0, 60);
        check(warm_seen == w0, "R2 all-mode single key", warm_seen - w0, 0);
        check(reason_key == 0, "R8 reason clear before request", int'(reason_key), 0);
        keys(0, 0, 6);

        // R3 and R5: both held, exactly one warm pulse
        w0 = warm_seen; s0 = shut_seen;
        keys(1, 1, 60);
        check(warm_seen == w0 + 1, "R3 timeout warm request", warm_seen - w0, 1);
        check(shut_seen == s0, "R5 no shutdown on warm action", shut_seen - s0, 0);
        check(reason_key == 1, "R8 reason set", int'(reason_key), 1);

        // R6: keep secondary pressed, re-press primary, no refire
        w0 = warm_seen;
        keys(0, 1, 20);
        keys(1, 1, 60);
        check(warm_seen == w0, "R6 no refire without full release", warm_seen - w0, 0);
        keys(0, 0, 6);
        keys(1, 1, 60);
        check(warm_seen == w0 + 1, "R6 refire after full release", warm_seen - w0, 1);
        keys(0, 0, 6);

        // R1: any-key mode, only primary enabled, secondary pressed alone
        cfg_mode_and = 0; cfg_en_sec = 0;
        w0 = warm_seen;
        keys(0, 1, 60);
        check(warm_seen == w0, "R1 disabled key ignored", warm_seen - w0, 0);
        keys(0, 0, 6);
        keys(1, 0, 60);
        check(warm_seen == w0 + 1, "R2 any-mode enabled key fires", warm_seen - w0, 1);
        keys(0, 0, 6);

        // R4: two short holds separated by a release do not add up
        w0 = warm_seen;
        keys(1, 0, 14);
        keys(0, 0, 4);
        keys(1, 0, 14);
        check(warm_seen == w0, "R4 counter cleared on release", warm_seen - w0, 0);
        keys(0, 0, 6);

        // R7: no enables, both modes, both keys held
        cfg_en_pri = 0; cfg_en_sec = 0;
        w0 = warm_seen; s0 = shut_seen;
        cfg_mode_and = 1;
        keys(1, 1, 60);
        keys(0, 0, 6);
        cfg_mode_and = 0;
        keys(1, 1, 60);
        check((warm_seen == w0) && (shut_seen == s0), "R7 no enables never fires",
              (warm_seen - w0) + (shut_seen - s0), 0);
        keys(0, 0, 6);

        // R5: shutdown action
        cfg_en_pri = 1; cfg_en_sec = 1; cfg_mode_and = 1; cfg_action = 1;
        w0 = warm_seen; s0 = shut_seen;
        keys(1, 1, 60);
        check(shut_seen == s0 + 1, "R5 shutdown request", shut_seen - s0, 1);
        check(warm_seen == w0, "R5 no warm on shutdown action", warm_seen - w0, 0);
        keys(0, 0, 6);

        // R3: zero timeout fires right after the condition is seen
        cfg_hold_ticks = '0; cfg_action = 0;
        w0 = warm_seen;
        keys(1, 1, 5);
        check(warm_seen == w0 + 1, "R3 zero timeout", warm_seen - w0, 1);
        keys(0, 0, 6);

        // R8: reason still set after everything released
        check(reason_key == 1, "R8 reason sticky", int'(reason_key), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule